// File: doc/BRIEF.md
# Always-On Boot Program Copy Engine

This block keeps a short boot program in a small SRAM that stays powered while the rest of the processor sleeps. On command it moves a run of dwords from that SRAM into the processor's instruction memory. The command comes either from software, through a control bit, or from a wake pulse that arrives after power returns. The engine moves one dword per clock. When it is done it clears the start bit and raises a done flag.

Software reaches everything through one 32-bit register port with a one-cycle read latency. That port holds the control and status words, the copy setup (source index, destination index, length) and four plain storage words that the boot program reads to find its images in external memory. The same port also gives direct dword access to the boot SRAM through a window in the upper half of the address space. The usual flow has four steps. Software fills the SRAM and programs the setup, then sets the start bit. It polls until the start bit reads back as zero. Finally it writes the arm bit alone, so that every later wake repeats the copy without software.

Top module: `bootcopy_engine`

## Requirements
- R1: Reset clears the start bit, the arm bit and the done flag, so the control word (byte offset 0x000) and the status word (0x010) both read 0 and no instruction-memory strobe occurs. Reset does not change the boot SRAM contents.
- R2: Read data appears on `reg_rdata` in the cycle after a read request. The source index (0x004) holds 8 bits, the destination index (0x008) holds 12 bits and the length (0x00C) holds 9 bits; upper bits read 0. Offsets 0x090, 0x094, 0x098 and 0x09C are full 32-bit storage words. Any other offset below 0x400 reads 0.
- R3: Byte offsets 0x400 to 0x7FF address the boot SRAM directly, and dword index = address bits [9:2].
- R4: Writing 1 to control bit 31 while idle starts a copy, counted from the clock edge that accepts it. Instruction-memory strobes then appear on N consecutive cycles, the first in the cycle after the next edge. The k-th strobe (k from 0) writes SRAM word src+k to instruction index dst+k.
- R5: Control bit 31 reads 1 while a copy runs. The edge N+1 after acceptance ends the copy: bit 31 then reads 0 and status bit 0 reads 1.
- R6: A length of 0 gives no strobe, and the copy completes at the first edge after acceptance.
- R7: While a copy runs, writes to the source, destination and length words are ignored, and a write of control bit 31 starts no extra copy.
- R8: Control bit 30 (arm) is readable and writable at any time. A one-cycle pulse on `wake_pulse` starts a copy only when arm is 1 and the engine is idle.
- R9: The done flag is cleared at the edge that starts a new copy.
- R10: Source indices wrap modulo the SRAM depth, and destination indices wrap modulo the instruction-memory depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register port access this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 11 | Byte offset within the block |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| wake_pulse | input | 1 | Power-up wake event, one cycle wide |
| imem_we | output | 1 | Instruction-memory write strobe |
| imem_addr | output | IMEM_AW | Instruction-memory dword index |
| imem_wdata | output | 32 | Instruction-memory write data |

## Verification
The main copy path is driven from a table of setups. The table covers a short run at index 0, a longer run from a mid-SRAM index, a run whose source passes the top of the SRAM, and a run whose destination passes the top of the instruction memory. Because every SRAM word holds a distinct value, a mix-up between the source index and the destination index, or a wrong wrap, shows up as wrong data at a known address. The strobe count and the cycle of the first strobe expose errors of one in the length or the latency. The control and status words are read on the exact edge where the copy ends, which pins down when completion is reported. Directed cases then cover a zero length, setup writes during a copy, wake pulses with arm clear and while busy, and a reset after the SRAM has been loaded.

// File: rtl/bootcopy_pkg.sv
// Shared constants for the boot copy engine: register word indices
// (byte offset / 4) and control bit positions.
package bootcopy_pkg;

    localparam int DATA_W = 32;

    // Register word indices inside the lower half of the block space
    localparam logic [7:0] WIDX_CTRL = 8'h00;
    localparam logic [7:0] WIDX_SRC  = 8'h01;
    localparam logic [7:0] WIDX_DST  = 8'h02;
    localparam logic [7:0] WIDX_LEN  = 8'h03;
    localparam logic [7:0] WIDX_STAT = 8'h04;
    localparam logic [7:0] WIDX_PTR0 = 8'h24;   // first of four storage words
    localparam int         NUM_PTR   = 4;

    // Control word bit positions
    localparam int CTRL_GO_BIT  = 31;
    localparam int CTRL_ARM_BIT = 30;

endpackage

// File: rtl/bootcopy_mem.sv
// Boot SRAM model: always-powered storage with one read/write port for the
// register window and one read-only port for the copy sequencer.
// Assumes: both read ports are registered (one-cycle latency); contents are
// not reset, so they survive a reset of the control logic.
module bootcopy_mem #(
    parameter int WORDS = 256,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          a_en,
    input  logic                          a_we,
    input  logic [AW-1:0]                 a_idx,
    input  logic [bootcopy_pkg::DATA_W-1:0] a_wdata,
    output logic [bootcopy_pkg::DATA_W-1:0] a_rdata,
    input  logic [AW-1:0]                 b_idx,
    output logic [bootcopy_pkg::DATA_W-1:0] b_rdata
);
    import bootcopy_pkg::*;

    logic [DATA_W-1:0] store [WORDS];

    // Port A: register-window write and registered read
    always_ff @(posedge clk) begin
        if (a_en && a_we) begin
            store[a_idx] <= a_wdata;
        end
        if (a_en && !a_we) begin
            a_rdata <= store[a_idx];
        end
    end

    // Port B: registered read for the copy sequencer
    always_ff @(posedge clk) begin
        b_rdata <= store[b_idx];
    end

endmodule

// File: rtl/bootcopy_seq.sv
// Copy sequencer: on a go pulse latches the setup, then walks the source and
// destination indices one dword per clock, issuing instruction-memory writes
// from the registered SRAM read data. The copy ends on the edge where the
// number of reads issued equals the length, which is N+1 edges after go.
// Assumes: go is only raised while idle (the register file gates it).
module bootcopy_seq #(
    parameter int BOOT_AW = 8,
    parameter int IMEM_AW = 12,
    parameter int CNT_W   = BOOT_AW + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            go,
    input  logic [BOOT_AW-1:0]              src,
    input  logic [IMEM_AW-1:0]              dst,
    input  logic [CNT_W-1:0]                len,
    output logic [BOOT_AW-1:0]              rd_idx,
    input  logic [bootcopy_pkg::DATA_W-1:0] rd_data,
    output logic                            busy,
    output logic                            done,
    output logic                            imem_we,
    output logic [IMEM_AW-1:0]              imem_addr,
    output logic [bootcopy_pkg::DATA_W-1:0] imem_wdata
);
    import bootcopy_pkg::*;

    logic [BOOT_AW-1:0] rd_idx_q;
    logic [IMEM_AW-1:0] wr_idx_q;
    logic [CNT_W-1:0]   len_q;
    logic [CNT_W-1:0]   issued_q;
    logic               busy_q;
    logic               done_q;
    logic               wr_pend_q;
    logic               last_edge;

    assign last_edge = busy_q && (issued_q == len_q);

    // Sequencer state: setup latch, index walk, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            wr_pend_q <= 1'b0;
            issued_q  <= '0;
            len_q     <= '0;
            rd_idx_q  <= '0;
            wr_idx_q  <= '0;
        end else if (go) begin
            busy_q    <= 1'b1;
            done_q    <= 1'b0;
            wr_pend_q <= 1'b0;
            issued_q  <= '0;
            len_q     <= len;
            rd_idx_q  <= src;
            wr_idx_q  <= dst;
        end else if (last_edge) begin
            busy_q    <= 1'b0;
            done_q    <= 1'b1;
            wr_pend_q <= 1'b0;
        end else if (busy_q) begin
            issued_q  <= issued_q + 1'b1;
            rd_idx_q  <= rd_idx_q + 1'b1;
            wr_pend_q <= 1'b1;
            if (wr_pend_q) begin
                wr_idx_q <= wr_idx_q + 1'b1;
            end
        end
    end

    assign rd_idx     = rd_idx_q;
    assign busy       = busy_q;
    assign done       = done_q;
    assign imem_we    = wr_pend_q;
    assign imem_addr  = wr_idx_q;
    assign imem_wdata = rd_data;

    // R4: strobes only occur during a copy
    p_strobe_in_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |-> busy);

    // R4: back-to-back strobes step the destination by one
    p_dst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_we && $past(imem_we)) |-> (imem_addr == $past(imem_addr) + 1'b1));

    // R9: a new copy clears done and shows busy
    p_go_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && !done));

    // R5: leaving busy always reports done
    p_finish_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6: zero length never strobes
    p_zero_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && len == '0) |=> (!imem_we ##1 !busy));

endmodule

// File: rtl/bootcopy_regs.sv
// Register file for the boot copy engine: control/status, copy setup,
// four storage words, the boot SRAM window and registered read-back.
// Assumes: one access per cycle; word index = reg_addr[9:2]; reg_addr[10]
// selects the SRAM window; the SRAM read port has one-cycle latency.
module bootcopy_regs #(
    parameter int BOOT_AW = 8,
    parameter int IMEM_AW = 12,
    parameter int CNT_W   = BOOT_AW + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic                            we,
    input  logic [10:0]                     addr,
    input  logic [bootcopy_pkg::DATA_W-1:0] wdata,
    output logic [bootcopy_pkg::DATA_W-1:0] rdata,
    input  logic                            wake,
    input  logic                            busy,
    input  logic                            done,
    output logic                            go,
    output logic [BOOT_AW-1:0]              src_q,
    output logic [IMEM_AW-1:0]              dst_q,
    output logic [CNT_W-1:0]                len_q,
    output logic                            mem_en,
    output logic                            mem_we,
    output logic [BOOT_AW-1:0]              mem_idx,
    output logic [bootcopy_pkg::DATA_W-1:0] mem_wdata,
    input  logic [bootcopy_pkg::DATA_W-1:0] mem_rdata
);
    import bootcopy_pkg::*;

    logic [7:0]        widx;
    logic              in_mem;
    logic              reg_wr;
    logic              reg_rd;
    logic              ctrl_wr;
    logic              arm_q;
    logic [DATA_W-1:0] ptr_q [NUM_PTR];
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rd_reg_q;
    logic              rd_from_mem_q;
    logic              unused_addr_lsb;

    assign widx            = addr[9:2];
    assign in_mem          = addr[10];
    assign reg_wr          = req && we && !in_mem;
    assign reg_rd          = req && !we;
    assign ctrl_wr         = reg_wr && (widx == WIDX_CTRL);
    assign unused_addr_lsb = ^addr[1:0];

    // Start decision: software start or armed wake, only while idle
    assign go = !busy && ((ctrl_wr && wdata[CTRL_GO_BIT]) || (wake && arm_q));

    // SRAM window wiring
    assign mem_en    = req && in_mem;
    assign mem_we    = we;
    assign mem_idx   = addr[BOOT_AW+1:2];
    assign mem_wdata = wdata;

    // Arm bit: writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (ctrl_wr) begin
            arm_q <= wdata[CTRL_ARM_BIT];
        end
    end

    // Copy setup: frozen while a copy runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
        end else if (reg_wr && !busy) begin
            case (widx)
                WIDX_SRC: src_q <= wdata[BOOT_AW-1:0];
                WIDX_DST: dst_q <= wdata[IMEM_AW-1:0];
                WIDX_LEN: len_q <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Storage words for the boot program
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (reg_wr && widx == WIDX_PTR0 + 8'(i)) begin
                ptr_q[i] <= wdata;
            end
        end
    end

    // Read-back selection for register offsets
    always_comb begin
        rd_val = '0;
        case (widx)
            WIDX_CTRL: begin
                rd_val[CTRL_GO_BIT]  = busy;
                rd_val[CTRL_ARM_BIT] = arm_q;
            end
            WIDX_SRC:  rd_val[BOOT_AW-1:0] = src_q;
            WIDX_DST:  rd_val[IMEM_AW-1:0] = dst_q;
            WIDX_LEN:  rd_val[CNT_W-1:0]   = len_q;
            WIDX_STAT: rd_val[0]           = done;
            default: begin
                for (int i = 0; i < NUM_PTR; i++) begin
                    if (widx == WIDX_PTR0 + 8'(i)) rd_val = ptr_q[i];
                end
            end
        endcase
    end

    // Registered read data and source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_reg_q      <= '0;
            rd_from_mem_q <= 1'b0;
        end else if (reg_rd) begin
            rd_reg_q      <= rd_val;
            rd_from_mem_q <= in_mem;
        end
    end

    assign rdata = rd_from_mem_q ? mem_rdata : rd_reg_q;

    // R7: setup stays fixed across a running copy
    p_setup_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) && $stable(len_q)));

    // R8: an armed wake while idle starts a copy
    p_armed_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && arm_q && !busy) |=> busy);

    // R8: a wake with arm clear and no software start leaves the engine idle
    p_unarmed_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !arm_q && !busy && !ctrl_wr) |=> !busy);

endmodule

// File: rtl/bootcopy_engine.sv
// Top of the always-on boot copy engine: ties the register file, the boot
// SRAM and the copy sequencer together.
// Assumes: BOOT_WORDS is 256 so that the SRAM fills the 0x400-0x7FF window.
module bootcopy_engine #(
    parameter int BOOT_WORDS = 256,
    parameter int IMEM_AW    = 12,
    localparam int BOOT_AW   = $clog2(BOOT_WORDS),
    localparam int CNT_W     = BOOT_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_req,
    input  logic               reg_we,
    input  logic [10:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               wake_pulse,
    output logic               imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [31:0]        imem_wdata
);
    import bootcopy_pkg::*;

    logic               go;
    logic               busy;
    logic               done;
    logic [BOOT_AW-1:0] src_q;
    logic [IMEM_AW-1:0] dst_q;
    logic [CNT_W-1:0]   len_q;
    logic               mem_en;
    logic               mem_we;
    logic [BOOT_AW-1:0] mem_idx;
    logic [DATA_W-1:0]  mem_wdata;
    logic [DATA_W-1:0]  mem_rdata;
    logic [BOOT_AW-1:0] seq_idx;
    logic [DATA_W-1:0]  seq_rdata;

    bootcopy_regs #(.BOOT_AW(BOOT_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (reg_req),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .wake      (wake_pulse),
        .busy      (busy),
        .done      (done),
        .go        (go),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .len_q     (len_q),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    bootcopy_mem #(.WORDS(BOOT_WORDS), .AW(BOOT_AW)) u_mem (
        .clk     (clk),
        .a_en    (mem_en),
        .a_we    (mem_we),
        .a_idx   (mem_idx),
        .a_wdata (mem_wdata),
        .a_rdata (mem_rdata),
        .b_idx   (seq_idx),
        .b_rdata (seq_rdata)
    );

    bootcopy_seq #(.BOOT_AW(BOOT_AW), .IMEM_AW(IMEM_AW), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .src        (src_q),
        .dst        (dst_q),
        .len        (len_q),
        .rd_idx     (seq_idx),
        .rd_data    (seq_rdata),
        .busy       (busy),
        .done       (done),
        .imem_we    (imem_we),
        .imem_addr  (imem_addr),
        .imem_wdata (imem_wdata)
    );

    // R1: no strobe while reset is held
    p_quiet_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !imem_we);

endmodule

// File: tb/tb_bootcopy_engine.sv
module tb_bootcopy_engine;

    localparam int IMEM_AW = 12;
    localparam int IMEM_N  = 1 << IMEM_AW;
    localparam int NVEC    = 4;
    // Copy table: source index, destination index, length
    localparam int V_SRC [NVEC] = '{0,   10,  250, 40};
    localparam int V_DST [NVEC] = '{256, 512, 768, 4094};
    localparam int V_LEN [NVEC] = '{4,   16,  12,  3};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               reg_req = 1'b0;
    logic               reg_we = 1'b0;
    logic [10:0]        reg_addr = '0;
    logic [31:0]        reg_wdata = '0;
    logic [31:0]        reg_rdata;
    logic               wake_pulse = 1'b0;
    logic               imem_we;
    logic [IMEM_AW-1:0] imem_addr;
    logic [31:0]        imem_wdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int strobes = 0;
    int first_cyc = -1;
    logic [31:0] imodel [IMEM_N];

    bootcopy_engine #(.IMEM_AW(IMEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_pulse(wake_pulse), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Instruction-memory observer, sampled away from the edge
    always @(negedge clk) begin
        if (imem_we === 1'b1) begin
            strobes++;
            if (first_cyc < 0) first_cyc = cyc;
            imodel[imem_addr] = imem_wdata;
        end
    end

    function automatic logic [31:0] pat(int i);
        return {16'hB007, 8'(i), ~8'(i)};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Callers are at a falling edge; each access spans one clock
    task automatic wr(int a, logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b1; reg_addr = 11'(a); reg_wdata = d;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_req = 1'b1; reg_we = 1'b0; reg_addr = 11'(a);
        @(negedge clk);
        reg_req = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse_wake();
        wake_pulse = 1'b1;
        @(negedge clk);
        wake_pulse = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Full copy with exact-edge completion checks (R4, R5, R6, R10)
    task automatic run_copy(int s, int d, int n, string tag);
        logic [31:0] v;
        int t0;
        int bad;
        wr(32'h004, 32'(s));
        wr(32'h008, 32'(d));
        wr(32'h00C, 32'(n));
        strobes = 0; first_cyc = -1;
        wr(32'h000, 32'h8000_0000);
        t0 = cyc;
        while (cyc < t0 + n) @(negedge clk);
        rd(32'h000, v);
        check(v[31] == 1'b1, {"R5 start still set on last edge ", tag}, v, 32'h8000_0000);
        rd(32'h010, v);
        check(v == 32'h1, {"R5 done after copy ", tag}, v, 32'h1);
        rd(32'h000, v);
        check(v[31] == 1'b0, {"R5 start self-cleared ", tag}, v, 32'h0);
        check(strobes == n, {"R4 strobe count ", tag}, 32'(strobes), 32'(n));
        if (n > 0)
            check(first_cyc == t0 + 1, {"R4 first strobe cycle ", tag},
                  32'(first_cyc - t0), 32'h1);
        else
            check(first_cyc < 0, {"R6 no strobe for zero length ", tag},
                  32'(first_cyc), 32'hFFFF_FFFF);
        bad = 0;
        for (int k = 0; k < n; k++) begin
            if (imodel[(d + k) % IMEM_N] !== pat((s + k) % 256)) begin
                if (bad == 0)
                    check(1'b0, {"R4 R10 copied data ", tag},
                          imodel[(d + k) % IMEM_N], pat((s + k) % 256));
                bad++;
            end
        end
        if (bad == 0) check(1'b1, {"R4 R10 copied data ", tag}, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int t0;
        for (int i = 0; i < IMEM_N; i++) imodel[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(32'h000, v); check(v == 32'h0, "R1 control after reset", v, 32'h0);
        rd(32'h010, v); check(v == 32'h0, "R1 status after reset", v, 32'h0);
        check(strobes == 0, "R1 no strobe after reset", 32'(strobes), 32'h0);

        // R3: fill the boot SRAM through its window, spot-read
        for (int i = 0; i < 256; i++) wr(32'h400 + 4 * i, pat(i));
        rd(32'h400, v);       check(v == pat(0), "R3 SRAM word 0", v, pat(0));
        rd(32'h7FC, v);       check(v == pat(255), "R3 SRAM word 255", v, pat(255));
        rd(32'h400 + 4 * 77, v); check(v == pat(77), "R3 SRAM word 77", v, pat(77));

        // R2: storage words, masked setup fields, unmapped offsets
        for (int i = 0; i < 4; i++) wr(32'h090 + 4 * i, 32'h1234_5000 + 32'(i));
        for (int i = 0; i < 4; i++) begin
            rd(32'h090 + 4 * i, v);
            check(v == 32'h1234_5000 + 32'(i), "R2 storage word", v, 32'h1234_5000 + 32'(i));
        end
        wr(32'h004, 32'hFFFF_FFFF);
        rd(32'h004, v); check(v == 32'hFF, "R2 source width", v, 32'hFF);
        wr(32'h00C, 32'hFFFF_FFFF);
        rd(32'h00C, v); check(v == 32'h1FF, "R2 length width", v, 32'h1FF);
        rd(32'h050, v); check(v == 32'h0, "R2 unmapped reads zero", v, 32'h0);

        // R4 R5 R10: table of copies
        for (int i = 0; i < NVEC; i++) run_copy(V_SRC[i], V_DST[i], V_LEN[i], $sformatf("vec%0d", i));

        // R6: zero length
        run_copy(5, 100, 0, "zero");

        // R9: done clears when a new copy is accepted
        wr(32'h004, 32'd0); wr(32'h008, 32'd1000); wr(32'h00C, 32'd6);
        wr(32'h000, 32'h8000_0000);
        rd(32'h010, v); check(v == 32'h0, "R9 done cleared by new start", v, 32'h0);
        idle(10);

        // R7: setup writes and a second start during a copy
        wr(32'h004, 32'd0); wr(32'h008, 32'd1100); wr(32'h00C, 32'd20);
        strobes = 0;
        wr(32'h000, 32'h8000_0000);
        wr(32'h004, 32'h33); wr(32'h00C, 32'd2); wr(32'h008, 32'd5);
        wr(32'h000, 32'h8000_0000);
        idle(40);
        rd(32'h004, v); check(v == 32'h0, "R7 source write ignored while busy", v, 32'h0);
        rd(32'h00C, v); check(v == 32'd20, "R7 length write ignored while busy", v, 32'd20);
        rd(32'h008, v); check(v == 32'd1100, "R7 dest write ignored while busy", v, 32'd1100);
        check(strobes == 20, "R7 restart while busy starts nothing", 32'(strobes), 32'd20);

        // R8: wake with arm clear does nothing
        wr(32'h00C, 32'd5); wr(32'h008, 32'd1300);
        strobes = 0;
        pulse_wake(); idle(10);
        check(strobes == 0, "R8 wake ignored when not armed", 32'(strobes), 32'h0);
        // R8: armed wake copies once; a second wake during the copy is ignored
        wr(32'h000, 32'h4000_0000);
        rd(32'h000, v); check(v == 32'h4000_0000, "R8 arm readback", v, 32'h4000_0000);
        pulse_wake(); pulse_wake(); idle(15);
        check(strobes == 5, "R8 armed wake copies once", 32'(strobes), 32'd5);
        check(imodel[1304] == pat(4), "R8 wake copy data", imodel[1304], pat(4));
        rd(32'h000, v); check(v == 32'h4000_0000, "R8 arm kept after wake copy", v, 32'h4000_0000);
        rd(32'h010, v); check(v == 32'h1, "R8 done after wake copy", v, 32'h1);

        // R1: reset keeps SRAM, clears control and status
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
        @(negedge clk);
        rd(32'h000, v); check(v == 32'h0, "R1 control cleared by reset", v, 32'h0);
        rd(32'h010, v); check(v == 32'h0, "R1 done cleared by reset", v, 32'h0);
        rd(32'h400 + 4 * 9, v); check(v == pat(9), "R1 SRAM kept over reset", v, pat(9));
        strobes = 0;
        pulse_wake(); idle(10);
        check(strobes == 0, "R1 arm cleared by reset", 32'(strobes), 32'h0);
        t0 = cyc;

        finish_run();
    end

endmodule